// File: doc/BRIEF.md
# Multi-Context Hardware Task Sequencer

This block runs one hardware task on a reconfigurable compute region by loading the task as a sequence of configuration context frames. Software writes a control word that holds a start bit, a frame count and a configuration base address. The block then steps through each frame in turn. For each frame it requests that frame's configuration data from a frame buffer, waits until the load is complete, lets the region run until the region reports that it has finished, and then holds the region in reset before the next frame begins.

Completion is reported only after the last programmed frame has run. It is shown as a done flag in a status word and as a level interrupt. Both stay up until software writes a clear bit. The status word also reports a busy flag, the state code and the index of the current frame. While a task is running, control writes are ignored.

A filter task that needs one frame and a matrix task that needs several frames use the same flow. A frame count of zero ends the task at once, without touching the frame buffer or the region.

Top module: `ctx_task_seq`

## Requirements
- R1: After a synchronous active-low reset, both register views read zero, and `cfg_req`, `region_run`, `region_rst` and `task_irq` are low.
- R2: A control write made in idle (bit 0 start, bit 1 clear, bits [8+CNT_W-1:8] frame count, bits [16+ADDR_W-1:16] base address) loads the count and the base. If start is 1, the block leaves idle on the next clock, and from then on the start bit reads back as 0. If start is 0, the block stays idle.
- R3: Every frame passes through request, configure, execute and finish, in that order. The status state codes are 1, 2, 3 and 4, idle is 0, region reset is 5 and done is 6. `cfg_req` stays high with a stable `cfg_addr` until `cfg_ack` is seen.
- R4: For frame k, `cfg_addr` equals base + k*FRAME_WORDS, taken modulo 2^ADDR_W.
- R5: Configure ends only on `cfg_done`. Execute ends only on `exec_done`. `region_run` is high exactly while the block is in execute.
- R6: Between two frames, `region_rst` is held high for exactly RST_CYCLES cycles, and the next frame's request follows immediately.
- R7: The done state is entered only at the finish of frame number (count-1). Exactly as many configuration loads take place as were programmed, and `task_irq` stays low until done.
- R8: A start with a frame count of zero goes from idle straight to done, with no configuration request.
- R9: Done, with `task_irq` high, holds until a control write sets the clear bit. That write returns the block to idle. Writes in done without the clear bit have no effect.
- R10: Control writes made while busy, or in done, leave the stored count, base and start bit unchanged and do not disturb the running task.
- R11: The status word (read with `reg_rd_sel`=1) holds busy in bit 0, done in bit 1, the state code in bits [4:2] and the current frame index in bits [8+CNT_W-1:8]. Busy is high in every state except idle and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control write strobe |
| reg_wdata | input | 32 | Control write data |
| reg_rd_sel | input | 1 | Read view select: 0 control, 1 status |
| reg_rdata | output | 32 | Read data of the selected view |
| cfg_req | output | 1 | Frame configuration request to the frame buffer |
| cfg_addr | output | ADDR_W | Configuration address of the current frame |
| cfg_ack | input | 1 | Frame buffer accepts the request |
| cfg_done | input | 1 | Frame configuration load finished |
| region_run | output | 1 | Compute region enabled for execution |
| region_rst | output | 1 | Compute region reset between frames |
| exec_done | input | 1 | Compute region finished the current frame |
| task_irq | output | 1 | Task complete interrupt, level |

## Verification
Directed tasks cover four cases. A single-frame task exercises the path with no region reset. A three-frame task exercises the reset and restart loop. A zero-frame task exercises the bypass straight to done. A fifteen-frame task with a base near the top of the address space tests that address generation wraps. Randomized tasks then vary the frame count, the base and the delays of the acknowledge, load-done and execute-done handshakes. These cases separate a design that counts frames correctly from one that stops early or late, and a design that waits on each handshake from one that skips ahead. Writes issued during execution and in done, with and without the clear bit, show whether they are ignored or acted on.

// File: rtl/ctx_seq_pkg.sv
// Package: shared state encoding and register field positions for the
// context task sequencer. Assumes a 32-bit register word.
package ctx_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CSTART = 3'd1,
        ST_CONFIG = 3'd2,
        ST_EXEC   = 3'd3,
        ST_CFIN   = 3'd4,
        ST_RRST   = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_e;

    localparam int unsigned REG_W         = 32;
    localparam int unsigned CTL_START_BIT = 0;
    localparam int unsigned CTL_CLEAR_BIT = 1;
    localparam int unsigned CTL_CNT_LSB   = 8;
    localparam int unsigned CTL_BASE_LSB  = 16;
    localparam int unsigned STS_BUSY_BIT  = 0;
    localparam int unsigned STS_DONE_BIT  = 1;
    localparam int unsigned STS_STATE_LSB = 2;
    localparam int unsigned STS_IDX_LSB   = 8;

endpackage

// File: rtl/ctx_seq_regs.sv
// Module: control/status register views of the sequencer.
// Holds the start bit, frame count and base address. Accepts writes only
// in idle. In done it turns a write with the clear bit into a one-cycle
// pulse. Assumes CNT_W <= 8 and ADDR_W <= 16 so that the fields fit the word.
module ctx_seq_regs
    import ctx_seq_pkg::*;
#(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 reg_rd_sel,
    output logic [REG_W-1:0]     reg_rdata,
    input  seq_state_e           state,
    input  logic [CNT_W-1:0]     frame_idx,
    input  logic                 start_clr,
    output logic                 start_q,
    output logic [CNT_W-1:0]     frames_q,
    output logic [ADDR_W-1:0]    base_q,
    output logic                 done_clr
);

    logic busy;
    logic [REG_W-1:0] ctl_view;
    logic [REG_W-1:0] sts_view;

    // Busy covers every state between leaving idle and reaching done.
    assign busy = (state != ST_IDLE) && (state != ST_DONE);

    // Latch the control fields on an idle write; clear start once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            frames_q <= '0;
            base_q   <= '0;
        end else if (start_clr) begin
            start_q <= 1'b0;
        end else if (reg_wr && (state == ST_IDLE)) begin
            start_q  <= reg_wdata[CTL_START_BIT];
            frames_q <= reg_wdata[CTL_CNT_LSB +: CNT_W];
            base_q   <= reg_wdata[CTL_BASE_LSB +: ADDR_W];
        end
    end

    // Clear request is honoured only while the task sits in done.
    assign done_clr = reg_wr && (state == ST_DONE) && reg_wdata[CTL_CLEAR_BIT];

    // Assemble both read views and select one.
    always_comb begin
        ctl_view = '0;
        ctl_view[CTL_START_BIT]              = start_q;
        ctl_view[CTL_CNT_LSB +: CNT_W]       = frames_q;
        ctl_view[CTL_BASE_LSB +: ADDR_W]     = base_q;
        sts_view = '0;
        sts_view[STS_BUSY_BIT]               = busy;
        sts_view[STS_DONE_BIT]               = (state == ST_DONE);
        sts_view[STS_STATE_LSB +: 3]         = 3'(state);
        sts_view[STS_IDX_LSB +: CNT_W]       = frame_idx;
        reg_rdata = reg_rd_sel ? sts_view : ctl_view;
    end

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && busy) |=> ($stable(frames_q) && $stable(base_q) && !start_q));

    // R2
    start_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !start_q);

endmodule

// File: rtl/ctx_seq_addr.sv
// Module: configuration address generator.
// Produces base + idx*FRAME_WORDS modulo 2^ADDR_W. If FRAME_WORDS is a
// power of two a shift is used, otherwise a constant multiply.
module ctx_seq_addr #(
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned FRAME_WORDS = 256
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    localparam int unsigned FW_LOG  = $clog2(FRAME_WORDS);
    localparam bit          FW_POW2 = ((1 << FW_LOG) == FRAME_WORDS);

    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] offset;

    // Widen the frame index to the address width.
    assign idx_ext = ADDR_W'(idx);

    generate
        if (FW_POW2) begin : g_shift
            // Power-of-two frame size: offset is a plain shift.
            assign offset = idx_ext << FW_LOG;
        end else begin : g_mult
            // Other frame sizes: multiply by the constant.
            assign offset = idx_ext * ADDR_W'(FRAME_WORDS);
        end
    endgenerate

    // Final address wraps naturally at the address width.
    assign addr = base + offset;

endmodule

// File: rtl/ctx_seq_ctrl.sv
// Module: per-task control state machine.
// Sequences request, configure, execute and finish for each frame. Between
// frames it holds region reset for RST_CYCLES cycles, and after the last
// frame it holds done. Assumes RST_CYCLES >= 1 and a frame count <= 2^CNT_W-1.
module ctx_seq_ctrl
    import ctx_seq_pkg::*;
#(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_q,
    input  logic [CNT_W-1:0] frames_q,
    input  logic             done_clr,
    input  logic             cfg_ack,
    input  logic             cfg_done,
    input  logic             exec_done,
    output seq_state_e       state,
    output logic [CNT_W-1:0] frame_idx,
    output logic             start_clr,
    output logic             cfg_req,
    output logic             region_run,
    output logic             region_rst,
    output logic             irq
);

    localparam int unsigned TMR_W = $clog2(RST_CYCLES + 1);

    seq_state_e        nxt;
    logic [TMR_W-1:0]  tmr_q;
    logic [CNT_W:0]    fin_cnt;
    logic              last_frame;

    // Frames finished so far, counting the one now closing.
    assign fin_cnt    = {1'b0, frame_idx} + (CNT_W+1)'(1);
    assign last_frame = (fin_cnt == {1'b0, frames_q});

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start_q) nxt = (frames_q == '0) ? ST_DONE : ST_CSTART;
            ST_CSTART: if (cfg_ack) nxt = ST_CONFIG;
            ST_CONFIG: if (cfg_done) nxt = ST_EXEC;
            ST_EXEC:   if (exec_done) nxt = ST_CFIN;
            ST_CFIN:   nxt = last_frame ? ST_DONE : ST_RRST;
            ST_RRST:   if (tmr_q == TMR_W'(RST_CYCLES - 1)) nxt = ST_CSTART;
            ST_DONE:   if (done_clr) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State, frame index and reset timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            frame_idx <= '0;
            tmr_q     <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE)
                frame_idx <= '0;
            else if ((state == ST_RRST) && (nxt == ST_CSTART))
                frame_idx <= frame_idx + 1'b1;
            if (state == ST_RRST)
                tmr_q <= tmr_q + 1'b1;
            else
                tmr_q <= '0;
        end
    end

    // Outputs decoded from the registered state.
    assign start_clr  = (state == ST_IDLE) && start_q;
    assign cfg_req    = (state == ST_CSTART);
    assign region_run = (state == ST_EXEC);
    assign region_rst = (state == ST_RRST);
    assign irq        = (state == ST_DONE);

    // Length of the current region reset pulse, kept for checking only.
    logic [TMR_W:0] rst_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          rst_len_q <= '0;
        else if (region_rst) rst_len_q <= rst_len_q + 1'b1;
        else                 rst_len_q <= '0;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> cfg_req);

    // R3
    config_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIG) |=> (state == ST_CONFIG || state == ST_EXEC));

    // R5
    exec_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region_run && !exec_done) |=> region_run);

    // R6
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(region_rst) |-> (rst_len_q == (TMR_W+1)'(RST_CYCLES) && cfg_req));

    // R8
    zero_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_q && frames_q == '0) |=> (irq && !cfg_req));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !done_clr) |=> irq);

endmodule

// File: rtl/ctx_task_seq.sv
// Module: top of the multi-context hardware task sequencer.
// Connects the register views, the control state machine and the address
// generator. Assumes the frame buffer and region handshake inputs are
// synchronous to clk.
module ctx_task_seq
    import ctx_seq_pkg::*;
#(
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned FRAME_WORDS = 256,
    parameter int unsigned RST_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd_sel,
    output logic [31:0]       reg_rdata,
    output logic              cfg_req,
    output logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_ack,
    input  logic              cfg_done,
    output logic              region_run,
    output logic              region_rst,
    input  logic              exec_done,
    output logic              task_irq
);

    seq_state_e        state;
    logic [CNT_W-1:0]  frame_idx;
    logic              start_clr;
    logic              start_q;
    logic [CNT_W-1:0]  frames_q;
    logic [ADDR_W-1:0] base_q;
    logic              done_clr;

    ctx_seq_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd_sel (reg_rd_sel),
        .reg_rdata  (reg_rdata),
        .state      (state),
        .frame_idx  (frame_idx),
        .start_clr  (start_clr),
        .start_q    (start_q),
        .frames_q   (frames_q),
        .base_q     (base_q),
        .done_clr   (done_clr)
    );

    ctx_seq_ctrl #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_q    (start_q),
        .frames_q   (frames_q),
        .done_clr   (done_clr),
        .cfg_ack    (cfg_ack),
        .cfg_done   (cfg_done),
        .exec_done  (exec_done),
        .state      (state),
        .frame_idx  (frame_idx),
        .start_clr  (start_clr),
        .cfg_req    (cfg_req),
        .region_run (region_run),
        .region_rst (region_rst),
        .irq        (task_irq)
    );

    ctx_seq_addr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS)) u_addr (
        .base (base_q),
        .idx  (frame_idx),
        .addr (cfg_addr)
    );

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> $stable(cfg_addr));

endmodule

// File: tb/tb_ctx_task_seq.sv
// Bench: directed and seeded random tasks against bench-computed expectations.
module tb_ctx_task_seq;

    localparam int CLK_PERIOD  = 10;
    localparam int CNT_W       = 4;
    localparam int ADDR_W      = 16;
    localparam int FRAME_WORDS = 256;
    localparam int RST_CYCLES  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic              reg_rd_sel = 1'b0;
    logic [31:0]       reg_rdata;
    logic              cfg_req;
    logic [ADDR_W-1:0] cfg_addr;
    logic              cfg_ack = 1'b0;
    logic              cfg_done = 1'b0;
    logic              region_run;
    logic              region_rst;
    logic              exec_done = 1'b0;
    logic              task_irq;

    int n_chk = 0;
    int n_fail = 0;

    ctx_task_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS),
                   .RST_CYCLES(RST_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata), .cfg_req(cfg_req),
        .cfg_addr(cfg_addr), .cfg_ack(cfg_ack), .cfg_done(cfg_done),
        .region_run(region_run), .region_rst(region_rst),
        .exec_done(exec_done), .task_irq(task_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl_word(bit st, bit clr, int frames, int base);
        logic [31:0] w;
        w = '0;
        w[0] = st;
        w[1] = clr;
        w[8 +: CNT_W] = CNT_W'(frames);
        w[16 +: ADDR_W] = ADDR_W'(base);
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(int base, int k);
        return ADDR_W'(base + k * FRAME_WORDS);
    endfunction

    function automatic logic [31:0] exp_status(bit busy, bit done, int st, int idx);
        logic [31:0] w;
        w = '0;
        w[0] = busy;
        w[1] = done;
        w[2 +: 3] = 3'(st);
        w[8 +: CNT_W] = CNT_W'(idx);
        return w;
    endfunction

    task automatic rd(input bit sel, output logic [31:0] v);
        reg_rd_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic write_ctl(input logic [31:0] w);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    // One full task with random handshake delays; expectations from the requirements.
    task automatic run_task(input int frames, input int base);
        logic [31:0] v;
        int loads;
        int n;
        int d;
        logic [31:0] ctl_exp;
        ctl_exp = ctl_word(1'b0, 1'b0, frames, base);
        loads = 0;
        write_ctl(ctl_word(1'b1, 1'b0, frames, base));
        @(negedge clk);
        rd(1'b0, v);
        chk(v == ctl_exp, "R2", "start self clear readback", v, ctl_exp);
        if (frames == 0) begin
            rd(1'b1, v);
            chk(v == exp_status(0, 1, 6, 0), "R8", "zero frames done status", v, exp_status(0, 1, 6, 0));
            chk(task_irq && !cfg_req, "R8", "zero frames irq/no req", {task_irq, cfg_req}, 2'b10);
        end else begin
            for (int k = 0; k < frames; k++) begin
                chk(cfg_req == 1'b1, "R3", "request at frame start", cfg_req, 1);
                chk(cfg_addr == exp_addr(base, k), "R4", "frame address", cfg_addr, exp_addr(base, k));
                rd(1'b1, v);
                chk(v == exp_status(1, 0, 1, k), "R11", "status in request", v, exp_status(1, 0, 1, k));
                d = $urandom_range(0, 3);
                for (int i = 0; i < d; i++) begin
                    @(negedge clk);
                    chk(cfg_req && cfg_addr == exp_addr(base, k), "R3", "request held before ack",
                        cfg_addr, exp_addr(base, k));
                end
                cfg_ack = 1'b1;
                @(negedge clk);
                cfg_ack = 1'b0;
                loads++;
                rd(1'b1, v);
                chk(v == exp_status(1, 0, 2, k), "R3", "configure state", v, exp_status(1, 0, 2, k));
                if (k == 0) begin
                    write_ctl(ctl_word(1'b1, 1'b1, (frames + 5) % 16, base ^ 16'h5a5a));
                    rd(1'b0, v);
                    chk(v == ctl_exp, "R10", "busy write ignored", v, ctl_exp);
                end
                d = $urandom_range(1, 4);
                for (int i = 0; i < d; i++) begin
                    @(negedge clk);
                    chk(!region_run && !cfg_req, "R5", "configure waits for load done", region_run, 0);
                end
                cfg_done = 1'b1;
                @(negedge clk);
                cfg_done = 1'b0;
                chk(region_run == 1'b1, "R5", "run in execute", region_run, 1);
                rd(1'b1, v);
                chk(v == exp_status(1, 0, 3, k), "R3", "execute state", v, exp_status(1, 0, 3, k));
                d = $urandom_range(0, 4);
                for (int i = 0; i < d; i++) begin
                    @(negedge clk);
                    chk(region_run == 1'b1, "R5", "execute waits for done", region_run, 1);
                end
                exec_done = 1'b1;
                @(negedge clk);
                exec_done = 1'b0;
                chk(!region_run && !task_irq, "R7", "finish, not yet done", {region_run, task_irq}, 0);
                @(negedge clk);
                if (k < frames - 1) begin
                    n = 0;
                    while (region_rst && n < 50) begin
                        n++;
                        @(negedge clk);
                    end
                    chk(n == RST_CYCLES, "R6", "region reset length", n, RST_CYCLES);
                end
            end
            chk(task_irq == 1'b1, "R7", "irq after last frame", task_irq, 1);
            chk(loads == frames, "R7", "load count", loads, frames);
            rd(1'b1, v);
            chk(v[1:0] == 2'b10 && v[4:2] == 3'd6, "R7", "done status", v[4:0], 5'b11010);
        end
        d = $urandom_range(1, 5);
        repeat (d) @(negedge clk);
        chk(task_irq == 1'b1, "R9", "done holds", task_irq, 1);
        write_ctl(ctl_word(1'b1, 1'b0, 7, 16'h0abc));
        rd(1'b0, v);
        chk(v == ctl_exp && task_irq, "R9", "write without clear ignored in done", v, ctl_exp);
        write_ctl(ctl_word(1'b0, 1'b1, 0, 0));
        rd(1'b1, v);
        chk(v[1:0] == 2'b00 && v[4:2] == 3'd0 && !task_irq, "R9", "clear returns idle", v[4:0], 0);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7331));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, v);
        chk(v == 0, "R1", "control after reset", v, 0);
        rd(1'b1, v);
        chk(v == 0, "R1", "status after reset", v, 0);
        chk({cfg_req, region_run, region_rst, task_irq} == 0, "R1", "outputs after reset",
            {cfg_req, region_run, region_rst, task_irq}, 0);

        write_ctl(ctl_word(1'b0, 1'b0, 2, 16'h0300));
        repeat (3) @(negedge clk);
        rd(1'b1, v);
        chk(v == exp_status(0, 0, 0, 0) && !cfg_req, "R2", "no start bit stays idle", v, 0);
        rd(1'b0, v);
        chk(v == ctl_word(1'b0, 1'b0, 2, 16'h0300), "R2", "fields loaded in idle", v,
            ctl_word(1'b0, 1'b0, 2, 16'h0300));

        run_task(1, 16'h0100);
        run_task(3, 16'h1234);
        run_task(0, 16'h0040);
        run_task(15, 16'hf800);
        for (int t = 0; t < 8; t++)
            run_task($urandom_range(0, 6), $urandom_range(0, 16'hffff));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule